// File: doc/BRIEF.md
# UART Interrupt and Status Front End

This block is the register-facing side of a simple byte UART. It holds a small transmit FIFO and a small receive FIFO and watches their fill levels. It also takes a receive-timeout pulse from the serial side and samples the clear-to-send pin. All of these conditions are gathered into one nine-bit status word. An enable mask sits over that word, and a masked pending view plus a single active-high interrupt line are derived from it.

Software works through six word-aligned registers. It pushes transmit bytes and pops receive bytes through two data ports. It clears sticky flags by writing ones to the status word. A control register flushes either FIFO, drives the request-to-send pin and shows the synchronised clear-to-send level. The serial shifter sits on the far side. It pushes received bytes in and takes transmit bytes out through a valid/pop pair.

Top module: `sio_irq_front`

## Requirements
- R1: Register index n sits at byte offset n*4, so only bus_addr[ADDR_W-1:2] is decoded. Index 0 (0x00) is the transmit data port, written. Index 1 (0x04) is the receive data port, read. Index 2 (0x08) is the status word. Index 3 (0x0C) is the enable mask, which reads back what was written. Index 4 (0x10) is the pending view. Index 5 (0x14) is control. Any other index reads 0.
- R2: Three status bits follow FIFO levels continuously, and writing a one to them has no effect: bit 0 (receive data present), bit 2 (receive FIFO full) and bit 6 (transmit FIFO full).
- R3: The sticky bits are bit 1 (receive level reached RX_AFULL_LVL), bit 3 (receive timeout pulse), bit 4 (receive overflow), bit 5 (transmit level fell to TX_AEMPTY_LVL or below), bit 7 (transmit FIFO became empty) and bit 8 (clear-to-send changed). Each is set by its event and held. Writing a one to a bit clears it, and bits written as zero are kept. Writing 0x1FF clears every sticky bit.
- R4: In the control word, writing bit 0 empties the transmit FIFO and writing bit 1 empties the receive FIFO. Both bits read back as 0. Bit 2 is a stored request-to-send value that drives rts_out.
- R5: Control bit 3 reads the clear-to-send input after a two-stage synchroniser. Each change of that synchronised level sets status bit 8.
- R6: The pending register reads the status word ANDed with the enable mask.
- R7: irq is registered and active high. It is set one cycle after any enabled status bit is set. Writing 0 to the enable mask drops irq without altering any status bit.
- R8: A write to the transmit port while that FIFO is full is dropped. A read of the receive port while that FIFO is empty returns 0 and changes nothing.
- R9: A receive push while the receive FIFO is full drops the byte and sets status bit 4.
- R10: Both FIFOs are first-in first-out. While the transmit FIFO holds data, tx_valid is high and tx_byte shows the oldest byte. tx_pop removes that byte.
- R11: After reset the status word, enable mask, pending view, control word, irq, rts_out and tx_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_push | input | 1 | Received byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| rx_timeout | input | 1 | Receive idle-timeout pulse |
| tx_pop | input | 1 | Shifter takes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO not empty |
| cts_in | input | 1 | Clear-to-send pin, asynchronous |
| rts_out | output | 1 | Request-to-send pin |
| irq | output | 1 | Interrupt, active high |

## Verification
The receive FIFO is filled one byte at a time through every level from 1 to 8 and then once past full. After each step the whole status word is compared with values computed from the count. This separates the level-following bits from the edge-set threshold bit and the overflow bit. The transmit FIFO is filled, drained byte by byte and flushed. This shows that the almost-empty and empty flags come from falling levels, and that a flush triggers them the same way. Clear writes with zero, level and mixed masks show that only sticky bits respond to write-one-to-clear. Masking checks show that irq follows the enable mask while the status word stays put.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int NFLAG = 9;

  typedef enum int unsigned {
    F_RX_DATA   = 0,
    F_RX_AFULL  = 1,
    F_RX_FULL   = 2,
    F_RX_TMO    = 3,
    F_RX_OVF    = 4,
    F_TX_AEMPTY = 5,
    F_TX_FULL   = 6,
    F_TX_EMPTY  = 7,
    F_CTS_DELTA = 8
  } flag_e;

  // bits that mirror a level rather than latch an event
  localparam logic [NFLAG-1:0] LEVEL_MASK = 9'h045;

  localparam int REG_TXD  = 0;
  localparam int REG_RXD  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_EN   = 3;
  localparam int REG_PEND = 4;
  localparam int REG_CTRL = 5;

  localparam int CTL_TXFLUSH = 0;
  localparam int CTL_RXFLUSH = 1;
  localparam int CTL_RTS     = 2;
  localparam int CTL_CTS     = 3;

  // one-cycle event when a condition turns true
  function automatic logic rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // sticky update: set wins over a clear in the same cycle
  function automatic logic [NFLAG-1:0] sticky_next(input logic [NFLAG-1:0] cur,
                                                   input logic [NFLAG-1:0] clr,
                                                   input logic [NFLAG-1:0] set);
    return ((cur & ~clr) | set) & ~LEVEL_MASK;
  endfunction
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign drop    = push & full & ~flush;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R8
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full); // R9
endmodule

// File: rtl/sio_status.sv
module sio_status
  import sio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] level_vec,
  input  logic [NFLAG-1:0] event_vec,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             en_we,
  input  logic [NFLAG-1:0] en_wdata,
  output logic [NFLAG-1:0] stat,
  output logic [NFLAG-1:0] en,
  output logic [NFLAG-1:0] pend,
  output logic             irq
);
  logic [NFLAG-1:0] sticky;

  assign stat = (level_vec & LEVEL_MASK) | sticky;
  assign pend = stat & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= '0;
      en     <= '0;
      irq    <= 1'b0;
    end else begin
      sticky <= sticky_next(sticky, clr_mask, event_vec);
      if (en_we) en <= en_wdata;
      irq <= |pend;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky & ~clr_mask) != '0) |=>
      ((sticky & $past(sticky & ~clr_mask)) == $past(sticky & ~clr_mask))); // R3
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_vec & ~LEVEL_MASK) != '0) |=>
      ((stat & $past(event_vec & ~LEVEL_MASK)) == $past(event_vec & ~LEVEL_MASK))); // R3
  AST_EN_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !irq); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en) != '0) |=> irq); // R7
endmodule

// File: rtl/sio_cts_sync.sv
module sio_cts_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic changed
);
  logic s1, seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      level <= 1'b0;
      seen  <= 1'b0;
    end else begin
      s1    <= pin;
      level <= s1;
      seen  <= level;
    end
  end

  assign changed = level ^ seen;
endmodule

// File: rtl/sio_irq_front.sv
module sio_irq_front
  import sio_pkg::*;
#(
  parameter int DEPTH         = 8,
  parameter int RX_AFULL_LVL  = 6,
  parameter int TX_AEMPTY_LVL = 2,
  parameter int ADDR_W        = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  input  logic              rx_timeout,
  input  logic              tx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              cts_in,
  output logic              rts_out,
  output logic              irq
);
  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  logic             wr_tx, wr_stat, wr_en, wr_ctrl, rd_rx;
  logic             tx_flush, rx_flush;
  logic [7:0]       rx_dout;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic             rx_full, rx_empty, rx_drop;
  logic             tx_full, tx_empty, tx_drop;
  logic             cts_lvl, cts_chg;
  logic             rts_q;
  logic             afull_c, aempty_c;
  logic             afull_p, aempty_p, txe_p;
  logic [NFLAG-1:0] lvl_v, evt_v, clr_v, stat, en, pend;
  logic             unused_bits;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr      = bus_sel & bus_we;
  assign rd      = bus_sel & ~bus_we;
  assign wr_tx   = wr && (int'(idx) == REG_TXD);
  assign wr_stat = wr && (int'(idx) == REG_STAT);
  assign wr_en   = wr && (int'(idx) == REG_EN);
  assign wr_ctrl = wr && (int'(idx) == REG_CTRL);
  assign rd_rx   = rd && (int'(idx) == REG_RXD);
  assign tx_flush = wr_ctrl & bus_wdata[CTL_TXFLUSH];
  assign rx_flush = wr_ctrl & bus_wdata[CTL_RXFLUSH];
  assign unused_bits = ^{bus_wdata[31:NFLAG], bus_addr[1:0], tx_drop};

  sio_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .din(rx_byte),
    .pop(rd_rx), .dout(rx_dout), .count(rx_cnt), .full(rx_full),
    .empty(rx_empty), .drop(rx_drop));

  sio_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(wr_tx),
    .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_byte), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty), .drop(tx_drop));

  sio_cts_sync u_cts (
    .clk(clk), .rst_n(rst_n), .pin(cts_in), .level(cts_lvl), .changed(cts_chg));

  assign afull_c  = (rx_cnt >= CNT_W'(RX_AFULL_LVL));
  assign aempty_c = (tx_cnt <= CNT_W'(TX_AEMPTY_LVL));

  // previous-condition state; reset values match the empty FIFOs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      afull_p  <= 1'b0;
      aempty_p <= 1'b1;
      txe_p    <= 1'b1;
      rts_q    <= 1'b0;
    end else begin
      afull_p  <= afull_c;
      aempty_p <= aempty_c;
      txe_p    <= tx_empty;
      if (wr_ctrl) rts_q <= bus_wdata[CTL_RTS];
    end
  end

  always_comb begin
    lvl_v = '0;
    lvl_v[F_RX_DATA] = ~rx_empty;
    lvl_v[F_RX_FULL] = rx_full;
    lvl_v[F_TX_FULL] = tx_full;
    evt_v = '0;
    evt_v[F_RX_AFULL]  = rise(afull_c, afull_p);
    evt_v[F_RX_TMO]    = rx_timeout;
    evt_v[F_RX_OVF]    = rx_drop;
    evt_v[F_TX_AEMPTY] = rise(aempty_c, aempty_p);
    evt_v[F_TX_EMPTY]  = rise(tx_empty, txe_p);
    evt_v[F_CTS_DELTA] = cts_chg;
    clr_v = wr_stat ? bus_wdata[NFLAG-1:0] : '0;
  end

  sio_status u_stat (
    .clk(clk), .rst_n(rst_n), .level_vec(lvl_v), .event_vec(evt_v),
    .clr_mask(clr_v), .en_we(wr_en), .en_wdata(bus_wdata[NFLAG-1:0]),
    .stat(stat), .en(en), .pend(pend), .irq(irq));

  assign tx_valid = ~tx_empty;
  assign rts_out  = rts_q;

  always_comb begin
    bus_rdata = '0;
    case (int'(idx))
      REG_RXD:  bus_rdata[7:0] = rx_dout;
      REG_STAT: bus_rdata[NFLAG-1:0] = stat;
      REG_EN:   bus_rdata[NFLAG-1:0] = en;
      REG_PEND: bus_rdata[NFLAG-1:0] = pend;
      REG_CTRL: begin
        bus_rdata[CTL_RTS] = rts_q;
        bus_rdata[CTL_CTS] = cts_lvl;
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_CTS_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cts_lvl) |=> stat[F_CTS_DELTA]); // R5
  AST_TX_VALID_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !tx_flush) |=> tx_valid); // R10
endmodule

// File: tb/sio_irq_front_bench.sv
module sio_irq_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_push = 1'b0, rx_timeout = 1'b0, tx_pop = 1'b0, cts_in = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [7:0]  tx_byte;
  logic        tx_valid, rts_out, irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  sio_irq_front u_sio_irq_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_timeout(rx_timeout),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .cts_in(cts_in), .rts_out(rts_out), .irq(irq));

  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_STAT = 5'h08,
                         A_EN = 5'h0C, A_PEND = 5'h10, A_CTRL = 5'h14;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO check FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("watchdog FAIL: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(2);
    // R11 reset state
    rd(A_STAT, v); chk("R11 status", v, 0);
    rd(A_EN, v);   chk("R11 enable", v, 0);
    rd(A_PEND, v); chk("R11 pending", v, 0);
    rd(A_CTRL, v); chk("R11 control", v, 0);
    chk("R11 irq/rts/valid", {29'd0, irq, rts_out, tx_valid}, 0);

    // R1 offsets: enable readback, unmapped index
    wr(A_EN, 32'h1FF); rd(A_EN, v); chk("R1 enable at 0x0C", v, 32'h1FF);
    wr(A_EN, 0);
    rd(5'h18, v); chk("R1 unmapped reads 0", v, 0);

    // R2/R3 receive level sweep
    for (int k = 1; k <= 8; k++) begin
      push(8'h30 + 8'(k));
      settle(3);
      rd(A_STAT, v);
      chk($sformatf("R2 R3 rx level %0d", k), v,
          32'h1 | ((k >= 6) ? 32'h2 : 0) | ((k == 8) ? 32'h4 : 0));
    end
    push(8'hEE); settle(3);
    rd(A_STAT, v); chk("R9 overflow flag", v, 32'h17);
    wr(A_STAT, 32'h5); rd(A_STAT, v); chk("R2 level bits ignore clear", v, 32'h17);
    wr(A_STAT, 32'h0); rd(A_STAT, v); chk("R3 zero write keeps", v, 32'h17);
    wr(A_STAT, 32'h2); rd(A_STAT, v); chk("R3 single clear", v, 32'h15);

    // R6 R7 masking
    wr(A_EN, 32'h10); settle(2);
    rd(A_PEND, v); chk("R6 pending", v, 32'h10);
    chk("R7 irq on", {31'd0, irq}, 1);
    wr(A_EN, 0); settle(2);
    chk("R7 irq masked", {31'd0, irq}, 0);
    rd(A_STAT, v); chk("R7 status kept", v, 32'h15);

    // R10 order, R8 empty read, R9 dropped byte
    for (int k = 1; k <= 8; k++) begin
      rd(A_RXD, v); chk($sformatf("R10 rx byte %0d", k), v, 32'h30 + k);
    end
    rd(A_RXD, v); chk("R8 R9 empty read zero", v, 0);
    settle(3);
    rd(A_STAT, v); chk("R2 rx drained", v, 32'h10);

    // R4 receive flush
    push(8'h50); push(8'h51); push(8'h52);
    wr(A_CTRL, 32'h2); settle(3);
    rd(A_STAT, v); chk("R4 rx flush status", v, 32'h10);
    rd(A_RXD, v);  chk("R4 rx flush data", v, 0);
    rd(A_CTRL, v); chk("R4 flush bits read 0", v, 0);
    wr(A_STAT, 32'h1FF); settle(2);
    rd(A_STAT, v); chk("R3 clear all", v, 0);

    // R8 R10 transmit fill, drop, drain
    for (int k = 0; k < 9; k++) wr(A_TXD, 32'hA0 + k);
    settle(3);
    rd(A_STAT, v); chk("R2 tx full", v, 32'h40);
    chk("R10 tx head", {23'd0, tx_valid, tx_byte}, 32'h1A0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk($sformatf("R10 R8 tx byte %0d", k), {23'd0, tx_valid, tx_byte}, 32'h1A0 + k);
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
    end
    settle(3);
    chk("R10 tx drained", {31'd0, tx_valid}, 0);
    rd(A_STAT, v); chk("R3 tx aempty and empty", v, 32'hA0);

    // R4 transmit flush
    wr(A_STAT, 32'h1FF);
    wr(A_TXD, 32'hC0); wr(A_TXD, 32'hC1); wr(A_TXD, 32'hC2); settle(3);
    rd(A_STAT, v); chk("R3 tx 3 no flags", v, 0);
    wr(A_CTRL, 32'h1); settle(3);
    chk("R4 tx flush valid", {31'd0, tx_valid}, 0);
    rd(A_STAT, v); chk("R4 tx flush flags", v, 32'hA0);

    // R4 RTS, R5 CTS
    wr(A_CTRL, 32'h4); settle(1);
    chk("R4 rts out", {31'd0, rts_out}, 1);
    wr(A_STAT, 32'h1FF);
    @(negedge clk); cts_in = 1'b1; settle(4);
    rd(A_CTRL, v); chk("R5 cts level", v, 32'hC);
    rd(A_STAT, v); chk("R5 cts delta rise", v, 32'h100);
    wr(A_STAT, 32'h100);
    @(negedge clk); cts_in = 1'b0; settle(4);
    rd(A_CTRL, v); chk("R5 cts low", v, 32'h4);
    rd(A_STAT, v); chk("R5 cts delta fall", v, 32'h100);

    // R3 timeout, R6 full mask, R7 clear drops irq
    wr(A_STAT, 32'h1FF);
    @(negedge clk); rx_timeout = 1'b1; @(negedge clk); rx_timeout = 1'b0;
    settle(2);
    rd(A_STAT, v); chk("R3 timeout flag", v, 32'h8);
    wr(A_EN, 32'h1FF); settle(2);
    rd(A_PEND, v); chk("R6 pending all", v, 32'h8);
    chk("R7 irq timeout", {31'd0, irq}, 1);
    wr(A_STAT, 32'h1FF); settle(2);
    chk("R7 irq after clear", {31'd0, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule